// File: doc/BRIEF.md
# Space Vector Switching Sequencer

This block drives the three upper-switch gate commands of a two-level, three-leg bridge using space vector modulation. A 16-bit reference phase advances by a programmable step once per carrier period. From that phase the block finds the 60-degree sector and the position inside it. It then derives the dwell times of the two neighbouring active vectors and of the zero vectors, using a quarter-wave sine table scaled by a modulation-index input.

Within each carrier period the block plays back a symmetric, centre-aligned switching pattern. A leading zero vector is followed by the two active vectors, the opposite zero vector in the centre, and then the mirror image. Every dwell computation happens at the start of a period and is held for the whole period, so changes on the inputs never disturb a pattern that is already running. Dead time, gate drivers and the power stage belong to other blocks.

Top module: `svm_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous, active high), the next cycle shows `gate_o`=000, `strobe_o`=0 and `sector_o`=0.
- R2: `gate_o` bit 2 is leg A, bit 1 is leg B and bit 0 is leg C, where 1 means the upper switch is on. Sector s (1..6) uses first vector P(s) and second vector P(s mod 6 + 1), where P(1..6) = 100, 110, 010, 011, 001, 101. The zero vectors are 000 and 111.
- R3: Period k after reset uses phase θk, the wrapping 16-bit sum of the steps latched at the k previous period starts (θ0 = 0). With X = 6·θk, `sector_o` = (X >> 16) + 1 and the in-sector fraction is f = X mod 65536.
- R4: `strobe_o` is high in the first cycle of every period, and consecutive strobes are exactly L cycles apart. L is `period_i` sampled at the period start, with values below 2 treated as 2. The first strobe comes in the second cycle after reset is released.
- R5: The dwell counts are Ta = (L·M·S[ia]·4730) >> 36 and Tb = (L·M·S[ib]·4730) >> 36. Here M = `mod_i`, S[k] = round(4095·sin(k·90°/64)), ia = ((65536−f)·683) >> 20 and ib = (f·683) >> 20.
- R6: The zero time is Z = L − Ta − Tb. With q = Z >> 2, the period runs as: 000 for q cycles, first-played active vector for its dwell >> 1, second-played active vector for its dwell >> 1, 111 for Z − 2q, second-played vector for the rest of its dwell, first-played vector for the rest of its dwell, and 000 for q.
- R7: When Ta + Tb > L, Ta becomes (Ta·L) / (Ta + Tb) (integer), Tb becomes L minus that value, and Z = 0.
- R8: In odd sectors (1, 3, 5) the first-played active vector is the sector's first vector with dwell Ta. In even sectors it is the sector's second vector with dwell Tb. This keeps adjacent non-empty steps one leg apart.
- R9: Changes to `period_i`, `step_i` or `mod_i` made during a period do not alter that period's length, sector or pattern. They take effect from the next period start.
- R10: `sector_o` holds one value for the whole of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; dwell times count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Carrier period length in clock cycles |
| step_i | input | 16 | Phase increment applied once per carrier period (65536 = one turn) |
| mod_i | input | 12 | Modulation index, 4096 = 1.0 |
| gate_o | output | 3 | Upper-switch commands for legs A, B, C |
| sector_o | output | 3 | Current sector 1..6, 0 before the first period |
| strobe_o | output | 1 | High in the first cycle of each carrier period |

## Verification
The checker module watches several properties on every cycle: the reset state, the sector range and its stability within a period, and that every vector shown belongs to the current sector's set. It also counts the exact spacing between strobes against the latched period length. The sequence of segments, their lengths, the saturation scaling and the rotation of the phase through the sectors can only be shown by the bench's scenarios. These sweep whole turns of the reference at several modulation depths and period lengths and compare run-length patterns against dwell times computed from the formulas. The deferred effect of mid-period input changes is likewise a bench scenario.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int PH_W  = 16;
    localparam int CNT_W = 16;
    localparam int MOD_W = 12;
    localparam int SIN_W = 12;
    localparam int LUT_N = 64;

    typedef logic [2:0] legs_t;

    typedef struct packed {
        logic [CNT_W-1:0] ta;
        logic [CNT_W-1:0] tb;
        logic [CNT_W-1:0] t0;
    } dwell_t;

    typedef struct packed {
        logic [CNT_W-1:0] e1;
        logic [CNT_W-1:0] e2;
        logic [CNT_W-1:0] e3;
        logic [CNT_W-1:0] e4;
        logic [CNT_W-1:0] e5;
        logic [CNT_W-1:0] e6;
    } bounds_t;

    typedef enum logic [2:0] {
        SEG_LEAD0, SEG_X1, SEG_Y1, SEG_MID7, SEG_Y2, SEG_X2, SEG_TAIL0
    } seg_e;

    // Active vector for a zero-based sector index, legs ordered A,B,C.
    function automatic legs_t active_vec(input logic [2:0] idx);
        case (idx)
            3'd0:    return 3'b100;
            3'd1:    return 3'b110;
            3'd2:    return 3'b010;
            3'd3:    return 3'b011;
            3'd4:    return 3'b001;
            3'd5:    return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    // Quarter-wave sine entry k of n, scaled to amp; evaluated at elaboration.
    function automatic int unsigned sin_code(input int k, input int n, input int amp);
        real x;
        real t;
        real s;
        x = 3.141592653589793 * real'(k) / (2.0 * real'(n));
        s = x;
        t = x;
        for (int j = 1; j <= 9; j++) begin
            t = -t * x * x / ((2.0 * real'(j)) * (2.0 * real'(j) + 1.0));
            s = s + t;
        end
        return $rtoi(s * real'(amp) + 0.5);
    endfunction

endpackage

// File: rtl/svm_phase_acc.sv
module svm_phase_acc #(
    parameter int PH_W = svm_pkg::PH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (load) phase <= phase + step;
    end
endmodule

// File: rtl/svm_sector_split.sv
module svm_sector_split #(
    parameter int PH_W    = svm_pkg::PH_W,
    parameter int LUT_N   = svm_pkg::LUT_N,
    parameter int LUT_AW  = $clog2(LUT_N),
    parameter int IDX_MUL = (LUT_N * 64 + 3) / 6,
    parameter int IDX_SH  = PH_W + 4
) (
    input  logic [PH_W-1:0]   phase,
    output logic [2:0]        sec,
    output logic [LUT_AW-1:0] idx_a,
    output logic [LUT_AW-1:0] idx_b
);
    logic [PH_W+2:0] prod;
    logic [PH_W-1:0] frac;
    logic [PH_W:0]   rem;
    logic [47:0]     ia_w;
    logic [47:0]     ib_w;

    always_comb begin
        prod  = {3'b000, phase} * (PH_W+3)'(6);
        sec   = prod[PH_W+2:PH_W];
        frac  = prod[PH_W-1:0];
        rem   = {1'b1, {PH_W{1'b0}}} - {1'b0, frac};
        ia_w  = (48'(rem) * 48'(IDX_MUL)) >> IDX_SH;
        ib_w  = (48'(frac) * 48'(IDX_MUL)) >> IDX_SH;
        idx_a = LUT_AW'(ia_w);
        idx_b = LUT_AW'(ib_w);
    end
endmodule

// File: rtl/svm_dwell.sv
module svm_dwell
    import svm_pkg::*;
#(
    parameter int LUT_AW  = $clog2(svm_pkg::LUT_N),
    parameter int INV_S60 = 4730,
    parameter int DW_SH   = svm_pkg::MOD_W + svm_pkg::SIN_W + 12
) (
    input  logic [CNT_W-1:0]  period,
    input  logic [MOD_W-1:0]  mod,
    input  logic [LUT_AW-1:0] idx_a,
    input  logic [LUT_AW-1:0] idx_b,
    output dwell_t            dw
);
    localparam int AMP = (1 << SIN_W) - 1;

    logic [SIN_W-1:0] rom [LUT_N];

    for (genvar k = 0; k < LUT_N; k++) begin : g_rom
        localparam int unsigned ENTRY = sin_code(k, LUT_N, AMP);
        assign rom[k] = SIN_W'(ENTRY);
    end

    logic [63:0]        pa;
    logic [63:0]        pb;
    logic [CNT_W-1:0]   ta_raw;
    logic [CNT_W-1:0]   tb_raw;
    logic [CNT_W:0]     sum;
    logic [2*CNT_W:0]   scaled;

    always_comb begin
        pa     = 64'(period) * 64'(mod) * 64'(rom[idx_a]) * 64'(INV_S60);
        pb     = 64'(period) * 64'(mod) * 64'(rom[idx_b]) * 64'(INV_S60);
        ta_raw = CNT_W'(pa >> DW_SH);
        tb_raw = CNT_W'(pb >> DW_SH);
        sum    = {1'b0, ta_raw} + {1'b0, tb_raw};
        scaled = '0;
        if (sum > {1'b0, period}) begin
            scaled = ((2*CNT_W+1)'(ta_raw) * (2*CNT_W+1)'(period)) / (2*CNT_W+1)'(sum);
            dw.ta  = CNT_W'(scaled);
            dw.tb  = period - CNT_W'(scaled);
            dw.t0  = '0;
        end else begin
            dw.ta  = ta_raw;
            dw.tb  = tb_raw;
            dw.t0  = period - CNT_W'(sum);
        end
    end
endmodule

// File: rtl/svm_seq.sv
module svm_seq
    import svm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_eff,
    input  dwell_t           dw,
    input  logic [2:0]       sec_in,
    output logic             load_o,
    output logic             valid_o,
    output legs_t            gate_o,
    output logic [2:0]       sector_o,
    output logic             strobe_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] plen_q;
    logic             valid_q;
    logic [2:0]       sec_q;
    bounds_t          bnd_q;
    legs_t            vx_q;
    legs_t            vy_q;

    bounds_t          nb;
    logic [CNT_W-1:0] tx;
    logic [CNT_W-1:0] ty;
    logic [CNT_W-1:0] q;
    logic [2:0]       sec_nx;
    legs_t            vn;
    legs_t            vn1;
    seg_e             seg;
    legs_t            g;

    assign load_o = !valid_q || (cnt_q == CNT_W'(plen_q - 1'b1));

    // Boundaries of the centre-aligned pattern for the period about to start.
    always_comb begin
        sec_nx = (sec_in == 3'd5) ? 3'd0 : sec_in + 3'd1;
        vn     = active_vec(sec_in);
        vn1    = active_vec(sec_nx);
        tx     = sec_in[0] ? dw.tb : dw.ta;
        ty     = sec_in[0] ? dw.ta : dw.tb;
        q      = dw.t0 >> 2;
        nb.e1  = q;
        nb.e2  = nb.e1 + (tx >> 1);
        nb.e3  = nb.e2 + (ty >> 1);
        nb.e4  = nb.e3 + (dw.t0 - (q << 1));
        nb.e5  = nb.e4 + (ty - (ty >> 1));
        nb.e6  = nb.e5 + (tx - (tx >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            plen_q  <= '0;
            valid_q <= 1'b0;
            sec_q   <= '0;
            bnd_q   <= '0;
            vx_q    <= 3'b000;
            vy_q    <= 3'b000;
        end else if (load_o) begin
            cnt_q   <= '0;
            plen_q  <= period_eff;
            valid_q <= 1'b1;
            sec_q   <= sec_in;
            bnd_q   <= nb;
            vx_q    <= sec_in[0] ? vn1 : vn;
            vy_q    <= sec_in[0] ? vn : vn1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if      (cnt_q < bnd_q.e1) seg = SEG_LEAD0;
        else if (cnt_q < bnd_q.e2) seg = SEG_X1;
        else if (cnt_q < bnd_q.e3) seg = SEG_Y1;
        else if (cnt_q < bnd_q.e4) seg = SEG_MID7;
        else if (cnt_q < bnd_q.e5) seg = SEG_Y2;
        else if (cnt_q < bnd_q.e6) seg = SEG_X2;
        else                       seg = SEG_TAIL0;
        case (seg)
            SEG_X1, SEG_X2: g = vx_q;
            SEG_Y1, SEG_Y2: g = vy_q;
            SEG_MID7:       g = 3'b111;
            default:        g = 3'b000;
        endcase
    end

    assign gate_o   = valid_q ? g : 3'b000;
    assign sector_o = valid_q ? sec_q + 3'd1 : 3'd0;
    assign strobe_o = valid_q && (cnt_q == '0);
    assign valid_o  = valid_q;
endmodule

// File: rtl/svm_sequencer.sv
module svm_sequencer
    import svm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [PH_W-1:0]   step_i,
    input  logic [MOD_W-1:0]  mod_i,
    output logic [2:0]        gate_o,
    output logic [2:0]        sector_o,
    output logic              strobe_o
);
    localparam int LUT_AW = $clog2(LUT_N);

    logic [PH_W-1:0]   phase;
    logic [2:0]        sec;
    logic [LUT_AW-1:0] idx_a;
    logic [LUT_AW-1:0] idx_b;
    logic [CNT_W-1:0]  period_eff;
    dwell_t            dw;
    logic              load;
    logic              run_valid;

    assign period_eff = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;

    svm_phase_acc #(.PH_W(PH_W)) u_acc (
        .clk(clk), .rst(rst), .load(load), .step(step_i), .phase(phase)
    );

    svm_sector_split #(.PH_W(PH_W), .LUT_N(LUT_N)) u_split (
        .phase(phase), .sec(sec), .idx_a(idx_a), .idx_b(idx_b)
    );

    svm_dwell #(.LUT_AW(LUT_AW)) u_dwell (
        .period(period_eff), .mod(mod_i), .idx_a(idx_a), .idx_b(idx_b), .dw(dw)
    );

    svm_seq u_seq (
        .clk(clk), .rst(rst), .period_eff(period_eff), .dw(dw), .sec_in(sec),
        .load_o(load), .valid_o(run_valid), .gate_o(gate_o),
        .sector_o(sector_o), .strobe_o(strobe_o)
    );
endmodule

// File: rtl/svm_sequencer_chk.sv
module svm_sequencer_chk #(
    parameter int CNT_W = svm_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] period_i,
    input logic [2:0]       gate_o,
    input logic [2:0]       sector_o,
    input logic             strobe_o,
    input logic             valid
);
    function automatic logic [2:0] ref_vec(input int s);
        case (s)
            1:       return 3'b100;
            2:       return 3'b110;
            3:       return 3'b010;
            4:       return 3'b011;
            5:       return 3'b001;
            6:       return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    logic [CNT_W-1:0] prev_p_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W:0]   run_q;
    logic             seen_q;
    logic [2:0]       next_sec;

    assign next_sec = (sector_o == 3'd6) ? 3'd1 : sector_o + 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_p_q <= '0;
            len_q    <= '0;
            run_q    <= '0;
            seen_q   <= 1'b0;
        end else begin
            prev_p_q <= (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
            if (strobe_o) begin
                len_q  <= prev_p_q;
                run_q  <= (CNT_W+1)'(1);
                seen_q <= 1'b1;
            end else begin
                run_q  <= run_q + 1'b1;
            end
        end
    end

    p_reset_v0_r1: assert property (@(posedge clk)
        rst |=> (gate_o == 3'b000 && !strobe_o && sector_o == 3'd0));

    p_sector_range_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sector_o >= 3'd1 && sector_o <= 3'd6));

    p_sector_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && !strobe_o) |-> $stable(sector_o));

    p_vec_in_sector_r2: assert property (@(posedge clk) disable iff (rst)
        valid |-> (gate_o == 3'b000 || gate_o == 3'b111 ||
                   gate_o == ref_vec(int'(sector_o)) ||
                   gate_o == ref_vec(int'(next_sec))));

    p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && seen_q) |-> (run_q == {1'b0, len_q}));
endmodule

bind svm_sequencer svm_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .period_i(period_i), .gate_o(gate_o),
    .sector_o(sector_o), .strobe_o(strobe_o), .valid(run_valid)
);

// File: tb/svm_sequencer_tb.sv
module svm_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] period_i = 16'd100;
    logic [15:0] step_i = 16'd0;
    logic [11:0] mod_i = 12'd0;
    logic [2:0]  gate_o;
    logic [2:0]  sector_o;
    logic        strobe_o;

    int checks = 0;
    int errors = 0;
    int stab [64];
    logic [2:0] exp_vec [8];
    int exp_len [8];
    int exp_n;
    int exp_sec;

    always #2 clk = ~clk;

    svm_sequencer u_dut (
        .clk(clk), .rst(rst), .period_i(period_i), .step_i(step_i), .mod_i(mod_i),
        .gate_o(gate_o), .sector_o(sector_o), .strobe_o(strobe_o)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        report();
    end

    function automatic logic [2:0] pvec(input int s);
        case (s)
            0: return 3'b100;
            1: return 3'b110;
            2: return 3'b010;
            3: return 3'b011;
            4: return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    function automatic void push(input logic [2:0] v, input int n);
        if (n == 0) return;
        if (exp_n > 0 && exp_vec[exp_n-1] == v) exp_len[exp_n-1] += n;
        else begin
            exp_vec[exp_n] = v;
            exp_len[exp_n] = n;
            exp_n++;
        end
    endfunction

    // Expected run-length pattern of one period from R3, R5..R8.
    function automatic void build(input int theta, input int p, input int m);
        longint x, f, ia, ib, ta, tb, t0, tx, ty, q;
        int sec;
        logic [2:0] vx, vy;
        x   = longint'(theta) * 6;
        sec = int'(x >>> 16);
        f   = x & 65535;
        ia  = ((65536 - f) * 683) >>> 20;
        ib  = (f * 683) >>> 20;
        ta  = (longint'(p) * m * stab[ia] * 4730) >>> 36;
        tb  = (longint'(p) * m * stab[ib] * 4730) >>> 36;
        if (ta + tb > p) begin
            ta = (ta * p) / (ta + tb);
            tb = p - ta;
        end
        t0 = p - ta - tb;
        exp_sec = sec + 1;
        if (sec % 2 == 0) begin
            vx = pvec(sec); vy = pvec((sec + 1) % 6); tx = ta; ty = tb;
        end else begin
            vx = pvec((sec + 1) % 6); vy = pvec(sec); tx = tb; ty = ta;
        end
        q = t0 / 4;
        exp_n = 0;
        push(3'b000, int'(q));
        push(vx, int'(tx / 2));
        push(vy, int'(ty / 2));
        push(3'b111, int'(t0 - 2 * q));
        push(vy, int'(ty - ty / 2));
        push(vx, int'(tx - tx / 2));
        push(3'b000, int'(q));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        checks++;
        if (gate_o !== 3'b000 || strobe_o !== 1'b0 || sector_o !== 3'd0) begin
            errors++;
            $display("FAIL R1 reset state: actual gate=%b strobe=%b sector=%0d expected 000/0/0",
                     gate_o, strobe_o, sector_o);
        end
        rst = 1'b0;
        tick();
        checks++;
        if (strobe_o !== 1'b1) begin
            errors++;
            $display("FAIL R4 first strobe: actual=%b expected=1", strobe_o);
        end
    endtask

    // Called at a strobe sample point; returns at the next one.
    task automatic measure(input int theta, input int p, input int m,
                           input int chg_at, input int np, input int nm, input int ns);
        logic [2:0] rv [16];
        int rl [16];
        int nr = 0;
        int cyc = 0;
        bit sec_bad = 0;
        bit pat_bad = 0;
        build(theta, p, m);
        do begin
            if (cyc == chg_at) begin
                period_i = 16'(np);
                mod_i    = 12'(nm);
                step_i   = 16'(ns);
            end
            if (int'(sector_o) != exp_sec) sec_bad = 1;
            if (nr > 0 && gate_o == rv[nr-1]) rl[nr-1]++;
            else if (nr < 16) begin
                rv[nr] = gate_o;
                rl[nr] = 1;
                nr++;
            end
            cyc++;
            tick();
        end while (!strobe_o && cyc < 70000);

        checks++;
        if (cyc != p) begin
            errors++;
            $display("FAIL R4/R9 period length theta=%0d: actual=%0d expected=%0d", theta, cyc, p);
        end
        checks++;
        if (sec_bad) begin
            errors++;
            $display("FAIL R3/R10 sector theta=%0d: actual=%0d expected=%0d", theta, sector_o, exp_sec);
        end
        checks++;
        if (nr != exp_n) pat_bad = 1;
        else for (int i = 0; i < nr; i++)
            if (rv[i] != exp_vec[i] || rl[i] != exp_len[i]) pat_bad = 1;
        if (pat_bad) begin
            errors++;
            $display("FAIL R2/R5/R6/R7/R8 pattern theta=%0d m=%0d: actual runs=%0d first=%b x%0d expected runs=%0d first=%b x%0d",
                     theta, m, nr, rv[0], rl[0], exp_n, exp_vec[0], exp_len[0]);
        end
    endtask

    task automatic sweep(input int p, input int m, input int st, input int n);
        int theta = 0;
        int p_eff = (p < 2) ? 2 : p;
        period_i = 16'(p);
        mod_i    = 12'(m);
        step_i   = 16'(st);
        do_reset();
        for (int k = 0; k < n; k++) begin
            measure(theta, p_eff, m, -1, 0, 0, 0);
            theta = (theta + st) & 16'hFFFF;
        end
    endtask

    initial begin
        for (int k = 0; k < 64; k++)
            stab[k] = $rtoi(4095.0 * $sin(3.141592653589793 * real'(k) / 128.0) + 0.5);

        // R2/R3/R5/R6/R8: one full turn at half modulation, no saturation
        sweep(200, 2048, 1366, 49);
        // R7: full modulation, zero time saturates near sector centres
        sweep(97, 4095, 1111, 60);
        // R4: period below the minimum acts as 2
        sweep(1, 2048, 4096, 8);
        // R6: zero modulation gives only zero vectors
        sweep(128, 0, 6000, 12);
        // R5 near-linear limit with coarse steps through every sector
        sweep(301, 3500, 10923, 12);

        // R9: changes inside a period apply from the next period
        period_i = 16'd100;
        mod_i    = 12'd1000;
        step_i   = 16'd5000;
        do_reset();
        measure(0, 100, 1000, 10, 150, 3000, 9000);
        measure(5000, 150, 3000, -1, 0, 0, 0);
        measure(14000, 150, 3000, 40, 60, 500, 100);
        measure(23000, 60, 500, -1, 0, 0, 0);

        report();
    end
endmodule